// File: doc/BRIEF.md
# Indexed Host Window with Interrupt Collection

This block is the host-facing glue of a two-channel communications controller. A byte-wide bus reaches a 32-byte configuration space. The lower half of that space holds identity bytes, a control/status byte, an auxiliary byte and an index register. The upper half, offsets 0x10 to 0x1F, is a shared data window. The value in the index register decides which internal function the window reaches: one of two frame-controller channels, the low or high register bank of the line interface, or the line-interface byte FIFO. The internal functions are modelled as plain register stubs and a small FIFO, so the decode, the bank selection and the control paths can be exercised on their own.

Three interrupt sources arrive active low: the line interface, the frame channels and the timer. The status byte reports them as they are. The host interrupt line is raised only when the interrupt-enable control bit is set and at least one source is low. When all three source bits read 1, nothing on this device needs service. A control bit holds the internal functions in reset. While that bit is set they are cleared and do not accept window writes.

Top module: `hwin_host_window`

## Requirements
- R1: After reset all control bits, the index register and the auxiliary byte are 0. The host interrupt and every control output are low.
- R2: Offset 0 reads the class byte parameter (default 0xA1) and offset 1 reads the revision byte parameter (default 0x02).
- R3: Offset 2 reads the three active-low source inputs in bits 2:0 (bit 0 line interface, bit 1 frame channels, bit 2 timer). Bits 7:3 read 0.
- R4: A write to offset 2 loads the control bits: bit 0 internal reset, bit 1 timer disable, bit 2 timer reset, bit 3 interrupt enable, bit 4 test. Bits 7:5 are dropped. Writing 0 clears all control bits.
- R5: The host interrupt is high exactly when interrupt enable is set and the source bits are not all 1.
- R6: A write to offset 3 keeps bit 7 (serial line bus enable) and bits 3:0 (interrupt select), drives both to outputs, and reads back with bits 6:4 as 0.
- R7: Offset 4 stores the full index byte written and reads it back unchanged.
- R8: Index codes 0x00, 0x01, 0x04 and 0x06 select four separate 16-byte register stubs: frame channel 1, frame channel 2, line-interface low bank and line-interface high bank. Address bits 3:0 choose the byte. Each stub keeps its own contents.
- R9: Index code 0x02 selects a byte FIFO of depth 4 at every window address. A write pushes, and a read returns the oldest byte and pops it.
- R10: A write to a full FIFO is dropped. A read from an empty FIFO returns 0x00 and changes nothing.
- R11: Any other index value makes window reads return 0x00, and window writes change no stub.
- R12: While the internal reset bit is set, the stubs and the FIFO are cleared and window writes are ignored. The contents stay cleared after release.
- R13: Offsets 5 to 0x0F read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset in the configuration space |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; pops the FIFO when the window selects it |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| src_irq_n | input | 3 | Active-low sources: bit 0 line interface, bit 1 frame channels, bit 2 timer |
| host_irq | output | 1 | Host interrupt, active high |
| unit_rst_o | output | 1 | Internal-function reset control |
| tmr_dis_o | output | 1 | Timer disable control |
| tmr_clr_o | output | 1 | Timer reset control |
| test_o | output | 1 | Test control bit |
| irq_sel_o | output | 4 | Interrupt select field |
| serbus_en_o | output | 1 | Serial line bus enable |

## Verification
The bench writes the same window address under different index codes. A decoder that shares storage between banks, or that folds the high bank onto the low one, would read back the wrong byte. It also selects index values that match no function, so a partial decode that lets such writes fall into a stub is caught when the stub is read later. The interrupt gate is driven with each single source low and with all sources high. This exposes a design that treats a high source bit as pending or that ignores the enable. The FIFO is overfilled and over-read to catch a pointer that wraps over stored data or pops an empty queue. The internal reset is checked by reading the window both while the reset is held and after it is released, and by checking that a write made during the reset did not land.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

    localparam int ADDR_W  = 5;
    localparam int WIN_AW  = 4;
    localparam int N_STUBS = 4;

    localparam logic [ADDR_W-1:0] OFS_ID_CLASS = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_ID_REV   = 5'h01;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_AUX      = 5'h03;
    localparam logic [ADDR_W-1:0] OFS_INDEX    = 5'h04;

    localparam logic [7:0] IDX_FRAME_A = 8'h00;
    localparam logic [7:0] IDX_FRAME_B = 8'h01;
    localparam logic [7:0] IDX_LFIFO   = 8'h02;
    localparam logic [7:0] IDX_LINE_LO = 8'h04;
    localparam logic [7:0] IDX_LINE_HI = 8'h06;

    localparam logic [7:0] AUX_KEEP = 8'h8F;

    typedef enum logic [2:0] {
        TGT_FRAME_A = 3'd0,
        TGT_FRAME_B = 3'd1,
        TGT_LINE_LO = 3'd2,
        TGT_LINE_HI = 3'd3,
        TGT_FIFO    = 3'd4,
        TGT_NONE    = 3'd5
    } win_tgt_e;

    typedef struct packed {
        logic test;
        logic irq_en;
        logic tmr_clr;
        logic tmr_dis;
        logic unit_rst;
    } ctrl_t;

    function automatic win_tgt_e decode_index(input logic [7:0] idx);
        case (idx)
            IDX_FRAME_A: return TGT_FRAME_A;
            IDX_FRAME_B: return TGT_FRAME_B;
            IDX_LINE_LO: return TGT_LINE_LO;
            IDX_LINE_HI: return TGT_LINE_HI;
            IDX_LFIFO:   return TGT_FIFO;
            default:     return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hwin_cfg_regs.sv
module hwin_cfg_regs
    import hwin_pkg::*;
#(
    parameter logic [7:0] ID_CLASS = 8'hA1,
    parameter logic [7:0] ID_REV   = 8'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [2:0]        src_n,
    output ctrl_t             ctrl,
    output logic [7:0]        index,
    output logic [7:0]        aux,
    output logic [7:0]        rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            index <= '0;
            aux   <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_CTRL:  ctrl  <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
                OFS_AUX:   aux   <= wdata & AUX_KEEP;
                OFS_INDEX: index <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_ID_CLASS: rdata = ID_CLASS;
            OFS_ID_REV:   rdata = ID_REV;
            OFS_CTRL:     rdata = {5'b0, src_n};
            OFS_AUX:      rdata = aux;
            OFS_INDEX:    rdata = index;
            default:      rdata = 8'h00;
        endcase
    end

    assert_index_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_INDEX) |=> index == $past(wdata));

    assert_aux_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_AUX) |=> (aux[6:4] == 3'b000 && aux[7] == $past(wdata[7])));

endmodule

// File: rtl/hwin_reg_stub.sv
module hwin_reg_stub #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int WORDS = 1 << AW;

    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    assert_stub_cleared_R12: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> rdata == 8'h00);

endmodule

// File: rtl/hwin_byte_fifo.sv
module hwin_byte_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  logic       pop,
    input  logic [7:0] din,
    output logic [7:0] dout
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [LW-1:0] level;
    logic          do_push, do_pop;

    assign do_pop  = pop && (level != '0);
    assign do_push = push && (level != FULL_LVL);

    always_ff @(posedge clk) begin
        if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    assign dout = (level == '0) ? 8'h00 : mem[rd_ptr];

    assert_fifo_bound_R10: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst || clr)
        (push && !pop && level == FULL_LVL) |=> level == FULL_LVL);

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst || clr)
        (pop && !push && level == '0) |=> level == '0);

endmodule

// File: rtl/hwin_host_window.sv
module hwin_host_window
    import hwin_pkg::*;
#(
    parameter logic [7:0] ID_CLASS   = 8'hA1,
    parameter logic [7:0] ID_REV     = 8'h02,
    parameter int         FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [2:0]        src_irq_n,
    output logic              host_irq,
    output logic              unit_rst_o,
    output logic              tmr_dis_o,
    output logic              tmr_clr_o,
    output logic              test_o,
    output logic [3:0]        irq_sel_o,
    output logic              serbus_en_o
);

    ctrl_t      ctrl;
    logic [7:0] index, aux, cfg_rdata, fifo_dout;
    logic [7:0] stub_rd [N_STUBS];
    logic [7:0] win_rdata;
    win_tgt_e   tgt;
    logic       win_hit, func_clr, win_wr, win_rd;

    hwin_cfg_regs #(.ID_CLASS(ID_CLASS), .ID_REV(ID_REV)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && !bus_addr[ADDR_W-1]),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .src_n (src_irq_n),
        .ctrl  (ctrl),
        .index (index),
        .aux   (aux),
        .rdata (cfg_rdata)
    );

    assign tgt      = decode_index(index);
    assign win_hit  = bus_addr[ADDR_W-1];
    assign func_clr = rst || ctrl.unit_rst;
    assign win_wr   = bus_wr && win_hit && !ctrl.unit_rst;
    assign win_rd   = bus_rd && win_hit && !ctrl.unit_rst;

    for (genvar s = 0; s < N_STUBS; s++) begin : g_stub
        hwin_reg_stub #(.AW(WIN_AW)) u_stub (
            .clk   (clk),
            .rst   (rst),
            .clr   (func_clr),
            .wr_en (win_wr && tgt == win_tgt_e'(s)),
            .addr  (bus_addr[WIN_AW-1:0]),
            .wdata (bus_wdata),
            .rdata (stub_rd[s])
        );
    end

    hwin_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .clr  (func_clr),
        .push (win_wr && tgt == TGT_FIFO),
        .pop  (win_rd && tgt == TGT_FIFO),
        .din  (bus_wdata),
        .dout (fifo_dout)
    );

    always_comb begin
        case (tgt)
            TGT_FRAME_A: win_rdata = stub_rd[0];
            TGT_FRAME_B: win_rdata = stub_rd[1];
            TGT_LINE_LO: win_rdata = stub_rd[2];
            TGT_LINE_HI: win_rdata = stub_rd[3];
            TGT_FIFO:    win_rdata = fifo_dout;
            default:     win_rdata = 8'h00;
        endcase
    end

    assign bus_rdata   = win_hit ? win_rdata : cfg_rdata;
    assign host_irq    = ctrl.irq_en && (src_irq_n != 3'b111);
    assign unit_rst_o  = ctrl.unit_rst;
    assign tmr_dis_o   = ctrl.tmr_dis;
    assign tmr_clr_o   = ctrl.tmr_clr;
    assign test_o      = ctrl.test;
    assign irq_sel_o   = aux[3:0];
    assign serbus_en_o = aux[7];

    assert_irq_quiet_after_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata == 8'h00) |=> !host_irq);

    assert_irq_none_pending_R5: assert property (@(posedge clk) disable iff (rst)
        (src_irq_n == 3'b111) |-> !host_irq);

    assert_window_held_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(unit_rst_o) && unit_rst_o && win_hit) |-> bus_rdata == 8'h00);

endmodule

// File: tb/test_hwin_host_window.sv
module test_hwin_host_window;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] CLS = 8'hA1;
    localparam logic [7:0] REV = 8'h02;
    localparam int         NV  = 30;

    // entry: {wr, addr[4:0], data[7:0], expected[7:0], req[3:0]}
    localparam logic [25:0] TBL [NV] = '{
        {1'b1, 5'h04, 8'h00, 8'h00, 4'd8},   // R8 index frame A
        {1'b1, 5'h13, 8'h5A, 8'h00, 4'd8},
        {1'b1, 5'h04, 8'h01, 8'h00, 4'd8},   // R8 index frame B
        {1'b1, 5'h13, 8'hC3, 8'h00, 4'd8},
        {1'b0, 5'h13, 8'h00, 8'hC3, 4'd8},
        {1'b1, 5'h04, 8'h00, 8'h00, 4'd8},
        {1'b0, 5'h13, 8'h00, 8'h5A, 4'd8},   // R8 frame A kept its byte
        {1'b1, 5'h04, 8'h04, 8'h00, 4'd8},   // R8 line low bank
        {1'b1, 5'h1F, 8'h11, 8'h00, 4'd8},
        {1'b1, 5'h04, 8'h06, 8'h00, 4'd8},   // R8 line high bank
        {1'b1, 5'h1F, 8'h22, 8'h00, 4'd8},
        {1'b0, 5'h1F, 8'h00, 8'h22, 4'd8},
        {1'b1, 5'h04, 8'h04, 8'h00, 4'd8},
        {1'b0, 5'h1F, 8'h00, 8'h11, 4'd8},
        {1'b0, 5'h04, 8'h00, 8'h04, 4'd7},   // R7
        {1'b1, 5'h04, 8'h03, 8'h00, 4'd11},  // R11 unused code
        {1'b0, 5'h13, 8'h00, 8'h00, 4'd11},
        {1'b1, 5'h13, 8'h77, 8'h00, 4'd11},
        {1'b1, 5'h04, 8'h00, 8'h00, 4'd11},
        {1'b0, 5'h13, 8'h00, 8'h5A, 4'd11},  // R11 write landed nowhere
        {1'b1, 5'h03, 8'hFF, 8'h00, 4'd6},   // R6
        {1'b0, 5'h03, 8'h00, 8'h8F, 4'd6},
        {1'b0, 5'h00, 8'h00, CLS,   4'd2},   // R2
        {1'b0, 5'h01, 8'h00, REV,   4'd2},
        {1'b0, 5'h07, 8'h00, 8'h00, 4'd13},  // R13
        {1'b0, 5'h0F, 8'h00, 8'h00, 4'd13},
        {1'b0, 5'h02, 8'h00, 8'h07, 4'd3},   // R3 nothing pending
        {1'b1, 5'h04, 8'hA5, 8'h00, 4'd7},   // R7 full byte kept
        {1'b0, 5'h04, 8'h00, 8'hA5, 4'd7},
        {1'b0, 5'h10, 8'h00, 8'h00, 4'd11}   // R11
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] src_irq_n = 3'b111;
    logic       host_irq, unit_rst_o, tmr_dis_o, tmr_clr_o, test_o, serbus_en_o;
    logic [3:0] irq_sel_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hwin_host_window #(.ID_CLASS(CLS), .ID_REV(REV), .FIFO_DEPTH(4)) i_hwin_host_window (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_irq_n(src_irq_n),
        .host_irq(host_irq), .unit_rst_o(unit_rst_o), .tmr_dis_o(tmr_dis_o),
        .tmr_clr_o(tmr_clr_o), .test_o(test_o), .irq_sel_o(irq_sel_o),
        .serbus_en_o(serbus_en_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [2:0] s);
        @(negedge clk);
        src_irq_n = s;
        #1;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check({2'b0, host_irq, unit_rst_o, tmr_dis_o, tmr_clr_o, test_o, serbus_en_o}, 8'h00, "R1 outputs");
        check({4'b0, irq_sel_o}, 8'h00, "R1 irq select");
        bus_read(5'h04, rd); check(rd, 8'h00, "R1 index");
        bus_read(5'h03, rd); check(rd, 8'h00, "R1 aux");

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][25]) begin
                bus_write(TBL[i][24:20], TBL[i][19:12]);
            end else begin
                bus_read(TBL[i][24:20], rd);
                check(rd, TBL[i][11:4], $sformatf("R%0d vector %0d", TBL[i][3:0], i));
            end
        end
        check({serbus_en_o, 3'b0, irq_sel_o}, 8'h8F, "R6 outputs");

        // R12 internal reset clears and locks the window
        bus_write(5'h04, 8'h00);
        bus_write(5'h13, 8'hAA);
        bus_read(5'h13, rd); check(rd, 8'hAA, "R8 frame A write");
        bus_write(5'h02, 8'h03);
        bus_read(5'h13, rd); check(rd, 8'h00, "R12 cleared during reset");
        bus_write(5'h13, 8'h44);
        bus_write(5'h02, 8'h0E);
        bus_read(5'h13, rd); check(rd, 8'h00, "R12 write during reset dropped");
        check({4'b0, unit_rst_o, tmr_dis_o, tmr_clr_o, test_o}, 8'h06, "R4 release pattern");

        // R4 / R5 control bits and interrupt gate
        bus_write(5'h02, 8'h1F);
        check({4'b0, unit_rst_o, tmr_dis_o, tmr_clr_o, test_o}, 8'h0F, "R4 all bits set");
        check({7'b0, host_irq}, 8'h00, "R5 no source low");
        set_src(3'b110); check({7'b0, host_irq}, 8'h01, "R5 line source");
        bus_read(5'h02, rd); check(rd, 8'h06, "R3 line source low");
        set_src(3'b101); check({7'b0, host_irq}, 8'h01, "R5 frame source");
        set_src(3'b011); check({7'b0, host_irq}, 8'h01, "R5 timer source");
        bus_read(5'h02, rd); check(rd, 8'h03, "R3 timer source low");
        bus_write(5'h02, 8'hE0);
        check({3'b0, host_irq, unit_rst_o, tmr_dis_o, tmr_clr_o, test_o}, 8'h00, "R4 upper bits dropped");
        bus_write(5'h02, 8'h08);
        check({7'b0, host_irq}, 8'h01, "R5 enable only");
        set_src(3'b000);
        bus_write(5'h02, 8'h00);
        check({7'b0, host_irq}, 8'h00, "R5 cleared control");
        set_src(3'b111);

        // R9 / R10 FIFO
        bus_write(5'h04, 8'h02);
        bus_read(5'h10, rd); check(rd, 8'h00, "R10 empty read");
        for (int k = 1; k <= 5; k++) bus_write(5'(16 + k), 8'(k * 16 + k));
        for (int k = 1; k <= 4; k++) begin
            bus_read(5'(16 + 2 * k), rd);
            check(rd, 8'(k * 16 + k), "R9 FIFO order");
        end
        bus_read(5'h1C, rd); check(rd, 8'h00, "R10 fifth byte dropped");
        bus_write(5'h10, 8'h9C);
        bus_read(5'h1E, rd); check(rd, 8'h9C, "R9 FIFO after empty pop");

        finish_run();
    end

endmodule